// File: doc/BRIEF.md
# Alternating Two-Bank Spark Pulse Steering

This block takes a single pulse-width-modulated timing stream and hands its pulses in turn to two identical capacitor-bank channels, A and B. Each bank gets two gate enables: a discharge enable, which carries the duty cycle of the pulse it was given, and a charge enable, which refills the bank while it is not the selected one. Because the banks take turns, the gap sees discharges at the full PWM rate while each bank fires at half of it.

Every discharge is qualified by that bank's own voltage window. A comparator flag at the upper threshold sets a per-bank ready latch. The lower-threshold flag, or the end of that bank's discharge pulse, clears it. A selected bank that is not ready lets its pulse go by with no output, and the turn still passes to the other bank. The PWM input and all comparator flags are asynchronous to the clock and are synchronized inside the block.

Top module: `spark_bank_steer`

## Requirements
- R1: While reset is high, and on the cycle after it, both discharge enables are 0 and both charge enables are 1. Bank A is selected for the first pulse after reset.
- R2: Successive PWM pulses go to bank A, then B, then A, and so on. In every vector port, bit 0 is bank A and bit 1 is bank B. At most one discharge enable is high in any cycle.
- R3: A bank's discharge enable is high only while the synchronized PWM is high, that bank is selected, and its ready latch is set. It rises and falls 3 clock cycles after the matching edge of pwm_in, so its width equals the input pulse width.
- R4: After the first pulse following reset, a bank's charge enable is 0 for the whole time that bank is selected, including the gaps between pulses, and 1 while the other bank is selected. It never follows the PWM duty cycle, and it is never 1 in the same cycle as that bank's discharge enable.
- R5: The selector changes banks only on the falling edge of the synchronized PWM. A pulse in progress stays on its bank until it ends.
- R6: A high-threshold flag sets that bank's ready latch. The latch stays set after the flag drops.
- R7: A low-threshold flag clears that bank's ready latch and wins over a simultaneous high-threshold flag. A low flag raised during a discharge ends that discharge 3 cycles later.
- R8: The end of a bank's pulse clears its ready latch, so the next discharge of that bank needs a new high-threshold flag.
- R9: When the selected bank is not ready, the pulse produces no discharge on either bank, and the next pulse still goes to the other bank.
- R10: From reset until the first PWM pulse arrives, both charge enables stay 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_in | input | 1 | Asynchronous PWM timing pulse stream |
| bank_lo_i | input | 2 | Low-threshold comparator flags, bit 0 bank A, bit 1 bank B (asynchronous) |
| bank_hi_i | input | 2 | High-threshold comparator flags, bit 0 bank A, bit 1 bank B (asynchronous) |
| dis_en_o | output | 2 | Discharge gate enables, bit 0 bank A, bit 1 bank B |
| chg_en_o | output | 2 | Charge gate enables, bit 0 bank A, bit 1 bank B |

## Verification
The assertions assume that a bank's low and high flags describe a real voltage and so are not raised together for long. They also assume that each PWM level lasts long enough to cross the synchronizer, so that every input pulse yields exactly one falling edge. The stimulus holds every PWM high and low phase for at least four clock cycles. Flags change only between pulses, except in the one case that aborts a discharge, and the bench raises both flags of a bank at once only in the test that checks which one wins.

// File: rtl/spark_steer_pkg.sv
package spark_steer_pkg;

    localparam int N_BANKS = 2;

    typedef enum logic {
        BANK_A = 1'b0,
        BANK_B = 1'b1
    } bank_e;

    typedef struct packed {
        logic lo;
        logic hi;
    } window_t;

    typedef struct packed {
        logic dis;
        logic chg;
    } gate_t;

    localparam gate_t GATE_IDLE = '{dis: 1'b0, chg: 1'b1};

    function automatic bank_e next_bank(input bank_e cur);
        return (cur == BANK_A) ? BANK_B : BANK_A;
    endfunction

    function automatic logic owns_turn(input bank_e cur, input bank_e me);
        return cur == me;
    endfunction

endpackage

// File: rtl/steer_sync_chain.sv
module steer_sync_chain #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= '0;
        end else begin
            stg[0] <= d_i;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/steer_turn_sel.sv
module steer_turn_sel
    import spark_steer_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  pwm_s,
    output bank_e sel_o,
    output logic  fall_o,
    output logic  live_nxt_o
);
    logic  pwm_d;
    logic  live_q;
    bank_e sel_q;

    assign fall_o     = pwm_d && !pwm_s;
    assign live_nxt_o = live_q || pwm_s;
    assign sel_o      = sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pwm_d  <= 1'b0;
            live_q <= 1'b0;
            sel_q  <= BANK_A;
        end else begin
            pwm_d  <= pwm_s;
            live_q <= live_nxt_o;
            if (fall_o) sel_q <= next_bank(sel_q);
        end
    end
endmodule

// File: rtl/steer_ready_latch.sv
module steer_ready_latch
    import spark_steer_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  window_t win_i,
    input  logic    pulse_end_i,
    output logic    ready_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ready_o <= 1'b0;
        end else if (win_i.lo || pulse_end_i) begin
            ready_o <= 1'b0;
        end else if (win_i.hi) begin
            ready_o <= 1'b1;
        end
    end
endmodule

// File: rtl/steer_bank_gate.sv
module steer_bank_gate
    import spark_steer_pkg::*;
#(
    parameter bank_e ME = BANK_A
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  pwm_s,
    input  bank_e sel_i,
    input  logic  ready_i,
    input  logic  lo_i,
    input  logic  live_nxt_i,
    output gate_t gate_o
);
    logic  mine;
    gate_t gate_d;

    always_comb begin
        mine       = owns_turn(sel_i, ME);
        gate_d.dis = pwm_s && mine && ready_i && !lo_i;
        gate_d.chg = !(live_nxt_i && mine);
    end

    always_ff @(posedge clk) begin
        if (rst) gate_o <= GATE_IDLE;
        else     gate_o <= gate_d;
    end
endmodule

// File: rtl/spark_bank_steer.sv
module spark_bank_steer
    import spark_steer_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pwm_in,
    input  logic [N_BANKS-1:0] bank_lo_i,
    input  logic [N_BANKS-1:0] bank_hi_i,
    output logic [N_BANKS-1:0] dis_en_o,
    output logic [N_BANKS-1:0] chg_en_o
);
    localparam int SYNC_W = 1 + 2 * N_BANKS;

    logic [SYNC_W-1:0]  raw_in;
    logic [SYNC_W-1:0]  sync_out;
    logic               pwm_s;
    logic [N_BANKS-1:0] lo_s;
    logic [N_BANKS-1:0] hi_s;
    logic               pwm_fall;
    logic               live_nxt;
    bank_e              sel_q;
    logic [N_BANKS-1:0] rdy_q;

    assign raw_in = {bank_hi_i, bank_lo_i, pwm_in};

    steer_sync_chain #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw_in),
        .q_o (sync_out)
    );

    assign pwm_s = sync_out[0];
    assign lo_s  = sync_out[N_BANKS:1];
    assign hi_s  = sync_out[2*N_BANKS:N_BANKS+1];

    steer_turn_sel u_sel (
        .clk        (clk),
        .rst        (rst),
        .pwm_s      (pwm_s),
        .sel_o      (sel_q),
        .fall_o     (pwm_fall),
        .live_nxt_o (live_nxt)
    );

    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        localparam bank_e ME = (b == 0) ? BANK_A : BANK_B;
        window_t win;
        gate_t   gate;
        logic    pulse_end;

        assign win.lo    = lo_s[b];
        assign win.hi    = hi_s[b];
        assign pulse_end = pwm_fall && owns_turn(sel_q, ME);

        steer_ready_latch u_rdy (
            .clk         (clk),
            .rst         (rst),
            .win_i       (win),
            .pulse_end_i (pulse_end),
            .ready_o     (rdy_q[b])
        );

        steer_bank_gate #(.ME(ME)) u_gate (
            .clk        (clk),
            .rst        (rst),
            .pwm_s      (pwm_s),
            .sel_i      (sel_q),
            .ready_i    (rdy_q[b]),
            .lo_i       (lo_s[b]),
            .live_nxt_i (live_nxt),
            .gate_o     (gate)
        );

        assign dis_en_o[b] = gate.dis;
        assign chg_en_o[b] = gate.chg;
    end
endmodule

// File: rtl/spark_bank_steer_chk.sv
module spark_bank_steer_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] dis_en_o,
    input logic [1:0] chg_en_o,
    input logic       pwm_s,
    input logic       pwm_fall,
    input logic       sel_q,
    input logic [1:0] rdy_q,
    input logic [1:0] lo_s
);
    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (dis_en_o == 2'b00 && chg_en_o == 2'b11)); // R1

    AST_ONE_BANK_FIRES: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dis_en_o)); // R2

    AST_FIRE_QUAL_A: assert property (@(posedge clk) disable iff (rst)
        dis_en_o[0] |-> ($past(pwm_s) && !$past(sel_q) && $past(rdy_q[0]))); // R3

    AST_FIRE_QUAL_B: assert property (@(posedge clk) disable iff (rst)
        dis_en_o[1] |-> ($past(pwm_s) && $past(sel_q) && $past(rdy_q[1]))); // R3

    AST_NO_SHORT_A: assert property (@(posedge clk) disable iff (rst)
        !(dis_en_o[0] && chg_en_o[0])); // R4

    AST_NO_SHORT_B: assert property (@(posedge clk) disable iff (rst)
        !(dis_en_o[1] && chg_en_o[1])); // R4

    AST_SEL_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        pwm_fall |=> (sel_q != $past(sel_q))); // R5

    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !pwm_fall |=> $stable(sel_q)); // R5

    AST_LO_CLEARS_A: assert property (@(posedge clk) disable iff (rst)
        lo_s[0] |=> !rdy_q[0]); // R7

    AST_LO_CLEARS_B: assert property (@(posedge clk) disable iff (rst)
        lo_s[1] |=> !rdy_q[1]); // R7

    AST_END_CLEARS_A: assert property (@(posedge clk) disable iff (rst)
        (pwm_fall && !sel_q) |=> !rdy_q[0]); // R8

    AST_END_CLEARS_B: assert property (@(posedge clk) disable iff (rst)
        (pwm_fall && sel_q) |=> !rdy_q[1]); // R8
endmodule

bind spark_bank_steer spark_bank_steer_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .dis_en_o (dis_en_o),
    .chg_en_o (chg_en_o),
    .pwm_s    (pwm_s),
    .pwm_fall (pwm_fall),
    .sel_q    (sel_q),
    .rdy_q    (rdy_q),
    .lo_s     (lo_s)
);

// File: tb/tb_spark_bank_steer.sv
module tb_spark_bank_steer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwm_in = 1'b0;
    logic [1:0] bank_lo_i = 2'b00;
    logic [1:0] bank_hi_i = 2'b00;
    logic [1:0] dis_en_o;
    logic [1:0] chg_en_o;

    int n_chk = 0;
    int n_fail = 0;
    int n_short = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    spark_bank_steer dut (
        .clk       (clk),
        .rst       (rst),
        .pwm_in    (pwm_in),
        .bank_lo_i (bank_lo_i),
        .bank_hi_i (bank_hi_i),
        .dis_en_o  (dis_en_o),
        .chg_en_o  (chg_en_o)
    );

    // R4 / R2 monitor: a bank never discharges while charging, banks never fire together
    always @(negedge clk) begin
        if (!rst && (((dis_en_o & chg_en_o) != 2'b00) || dis_en_o == 2'b11)) n_short++;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One PWM pulse of width cycles, then a 6-cycle gap; checks which bank fired and for how long
    task automatic run_pulse(input int width, input logic [1:0] exp_dis, input string tag,
                             output logic [1:0] mid_chg);
        int hits = 0;
        int stray = 0;
        pwm_in = 1'b1;
        for (int k = 1; k <= width; k++) begin
            @(negedge clk);
            if (k == 3) begin
                chk(dis_en_o == exp_dis, {tag, " mid-pulse discharge"}, dis_en_o, exp_dis);
                mid_chg = chg_en_o;
            end
            if (exp_dis != 2'b00 && dis_en_o == exp_dis) hits++;
            if ((dis_en_o & ~exp_dis) != 2'b00) stray++;
        end
        pwm_in = 1'b0;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            if (exp_dis != 2'b00 && dis_en_o == exp_dis) hits++;
            if ((dis_en_o & ~exp_dis) != 2'b00) stray++;
        end
        chk(hits == ((exp_dis != 2'b00) ? width : 0), {tag, " discharge width"},
            hits, (exp_dis != 2'b00) ? width : 0);
        chk(stray == 0, {tag, " stray discharge"}, stray, 0);
    endtask

    task automatic t_reset;
        idle(3);
        chk(dis_en_o == 2'b00, "R1 reset discharge", dis_en_o, 0);
        chk(chg_en_o == 2'b11, "R1 reset charge", chg_en_o, 3);
        rst = 1'b0;
        idle(6);
        chk(chg_en_o == 2'b11, "R10 charge before first pulse", chg_en_o, 3);
        chk(dis_en_o == 2'b00, "R10 idle discharge", dis_en_o, 0);
    endtask

    task automatic t_skip;
        logic [1:0] mc;
        bank_hi_i = 2'b10;
        idle(6);
        run_pulse(6, 2'b00, "R9 skip not-ready A", mc);
        chk(mc == 2'b10, "R4 selected A not charging", mc, 2);
        chk(chg_en_o == 2'b01, "R9 turn passed to B", chg_en_o, 1);
        run_pulse(6, 2'b10, "R9 B fires after skip", mc);
        bank_hi_i = 2'b00;
        idle(4);
    endtask

    task automatic t_alternate;
        logic [1:0] mc;
        bank_hi_i = 2'b11;
        idle(6);
        run_pulse(7, 2'b01, "R2 first to A", mc);
        chk(mc == 2'b10, "R4 charge during A pulse", mc, 2);
        chk(chg_en_o == 2'b01, "R4 charge held off in B gap", chg_en_o, 1);
        run_pulse(5, 2'b10, "R2 second to B", mc);
        chk(mc == 2'b01, "R4 charge during B pulse", mc, 1);
        chk(chg_en_o == 2'b10, "R4 charge held off in A gap", chg_en_o, 2);
        run_pulse(9, 2'b01, "R3 third to A width 9", mc);
        bank_hi_i = 2'b00;
        bank_lo_i = 2'b11;
        idle(2);
        bank_lo_i = 2'b00;
        idle(5);
    endtask

    task automatic t_latch_hold;
        logic [1:0] mc;
        bank_hi_i = 2'b10;
        idle(2);
        bank_hi_i = 2'b00;
        idle(6);
        run_pulse(6, 2'b10, "R6 latch held after flag drop", mc);
        run_pulse(6, 2'b00, "R9 A not ready", mc);
        run_pulse(6, 2'b00, "R8 latch cleared by pulse end", mc);
    endtask

    task automatic t_low;
        logic [1:0] mc;
        bank_hi_i = 2'b01;
        bank_lo_i = 2'b01;
        idle(6);
        run_pulse(6, 2'b00, "R7 low wins over high", mc);
        bank_lo_i = 2'b00;
        idle(6);
        run_pulse(6, 2'b00, "R9 B not ready", mc);
        pwm_in = 1'b1;
        idle(3);
        chk(dis_en_o == 2'b01, "R3 abort case fires A", dis_en_o, 1);
        bank_lo_i = 2'b01;
        bank_hi_i = 2'b00;
        idle(3);
        chk(dis_en_o == 2'b00, "R7 low ends discharge", dis_en_o, 0);
        idle(2);
        pwm_in = 1'b0;
        idle(6);
        bank_lo_i = 2'b00;
        idle(4);
        run_pulse(6, 2'b00, "R9 B still not ready", mc);
        run_pulse(6, 2'b00, "R7 A latch stays clear", mc);
    endtask

    task automatic t_latency;
        bank_hi_i = 2'b10;
        idle(6);
        pwm_in = 1'b1;
        idle(2);
        chk(dis_en_o == 2'b00, "R3 not yet at 2 cycles", dis_en_o, 0);
        idle(1);
        chk(dis_en_o == 2'b10, "R3 rises at 3 cycles", dis_en_o, 2);
        idle(3);
        pwm_in = 1'b0;
        idle(2);
        chk(dis_en_o == 2'b10, "R5 pulse stays on B", dis_en_o, 2);
        idle(1);
        chk(dis_en_o == 2'b00, "R3 falls at 3 cycles", dis_en_o, 0);
        idle(2);
        chk(chg_en_o == 2'b10, "R5 turn moved to A after fall", chg_en_o, 2);
        bank_hi_i = 2'b00;
        idle(4);
    endtask

    initial begin
        t_reset();
        t_skip();
        t_alternate();
        t_latch_hold();
        t_low();
        t_latency();
        chk(n_short == 0, "R4 no charge/discharge overlap", n_short, 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule